// File: doc/BRIEF.md
# Page-Mode External Memory Bus Sequencer

This block runs a byte-wide external memory bus in page mode for an 8-bit core. The core asks for a code fetch, a data read or a data write. Each request carries a 16-bit address and, for a write, a data byte. The sequencer remembers the upper address byte of the current external page. When a new access targets a different page, it spends one clock presenting the new upper byte with the latch strobe before it moves data. When the access stays in the same page, it goes straight to the transfer clocks, and the latch strobe stays low.

A two-bit page-timing select sets the base width of the data strobes and the rules for when a data access disturbs the open page. In one-cycle mode every data access is a forced page change, and so is the code fetch after it. In two-cycle mode a data access opens a new page only when its upper byte differs. In four-cycle mode a data access never opens a page. A one-bit layout select chooses which port carries the multiplexed byte. A stretch count widens only the data strobes, four clocks per step. Consecutive same-page code fetches keep the program store enable high without a gap.

Top module: `page_bus_seq`

## Requirements
- R1: After reset all strobes, `rsp_ready` and both output enables are low. The stored page is invalid, so the first access of any kind is a page miss.
- R2: A page miss is one clock with `ale` high while `p2_out` shows the upper address byte, and a strobe follows in the next clock. A code fetch whose upper byte equals the stored page gives no `ale` clock, and one whose upper byte differs gives one.
- R3: With `page_mode`=00, every data access is a miss even when its upper byte matches. The next code fetch after such an access is also a miss. Later code fetches to the same page are hits.
- R4: With `page_mode`=01, a data access is a miss only if its upper byte differs from the stored page, and a miss stores that byte as the new page.
- R5: With `page_mode`=10 or 11, a data access never gives an `ale` clock once the page is valid, and it leaves the stored page unchanged.
- R6: A code fetch holds `psen` high for exactly one clock. When a same-page code fetch is accepted in the clock where `rsp_ready` is high, `psen` stays high with no gap. At most one of `psen`, `rd_strobe` and `wr_strobe` is high at any time.
- R7: A data strobe lasts B + 4*`stretch` clocks, where B is 1, 2 or 4 for `page_mode` 00, 01 and 10/11.
- R8: With `bus_layout`=0, the low address byte is on `p2_out` during the strobe clocks. Data moves on port 0: `p0_out` drives the write byte, and `p0_oe` is low for reads and fetches.
- R9: With `bus_layout`=1, `p0_out` shows the low address byte in the miss clock and in the strobe clocks. Data moves on port 2: `p2_out` drives the write byte, and `p2_oe` is low for reads and fetches.
- R10: `rsp_ready` is high for exactly one clock, the last strobe clock. For fetches and reads, `rsp_rdata` then equals the data port's input.
- R11: A `req_valid` pulse is accepted only while the bus is idle or while `rsp_ready` is high. A pulse at any other time changes neither the bus activity nor the stored page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-clock request pulse |
| req_kind | input | 2 | 00 code fetch, 01 data read, 10 data write, 11 data read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write byte |
| page_mode | input | 2 | Page-timing select, sampled at accept |
| bus_layout | input | 1 | 0: data on port 0; 1: data on port 2 |
| stretch | input | 3 | Data-strobe stretch steps |
| rsp_ready | output | 1 | Completion pulse |
| rsp_rdata | output | 8 | Read byte, valid with `rsp_ready` |
| ale | output | 1 | Address latch strobe |
| psen | output | 1 | Program store enable, active high |
| rd_strobe | output | 1 | Data read strobe, active high |
| wr_strobe | output | 1 | Data write strobe, active high |
| p0_out | output | 8 | Port 0 output value |
| p0_oe | output | 1 | Port 0 drive enable |
| p0_in | input | 8 | Port 0 input value |
| p2_out | output | 8 | Port 2 output value |
| p2_oe | output | 1 | Port 2 drive enable |
| p2_in | input | 8 | Port 2 input value |

## Verification
A wrong stored page, or a wrong forced-miss flag, shows up at the ports on the very next accepted access: an `ale` clock appears where none belongs or is missing, and every strobe after it moves by one clock. A wrong strobe counter shows up as a strobe of the wrong width, with `rsp_ready` landing in the wrong clock. The bench therefore runs the page, forced-miss and four-cycle rules in sequence, so that each access depends on the page state left by the one before. After every access it compares the `ale` count, the strobe width, the port contents and the returned byte.

// File: rtl/page_bus_pkg.sv
package page_bus_pkg;

  localparam logic [1:0] KIND_CODE  = 2'b00;
  localparam logic [1:0] KIND_WRITE = 2'b10;
  localparam logic [1:0] PG_ONE     = 2'b00;
  localparam logic [1:0] PG_TWO     = 2'b01;

  typedef enum logic [1:0] {
    BUS_IDLE = 2'b00,
    BUS_MISS = 2'b01,
    BUS_XFER = 2'b10
  } bus_state_t;

  // Base data-strobe width per page-timing select.
  function automatic int unsigned data_base_clocks(input logic [1:0] mode);
    case (mode)
      PG_ONE:  return 1;
      PG_TWO:  return 2;
      default: return 4;
    endcase
  endfunction

  // Total strobe clocks for one access.
  function automatic int unsigned strobe_clocks(input logic is_data,
                                                input logic [1:0] mode,
                                                input int unsigned steps);
    if (!is_data) return 1;
    return data_base_clocks(mode) + 4 * steps;
  endfunction

  // Page-miss decision for an access about to be accepted.
  function automatic logic miss_rule(input logic valid,
                                     input logic force_next,
                                     input logic is_data,
                                     input logic [1:0] mode,
                                     input logic same_page);
    if (!valid) return 1'b1;
    if (!is_data) return force_next || !same_page;
    case (mode)
      PG_ONE:  return 1'b1;
      PG_TWO:  return !same_page;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/page_tracker.sv
module page_tracker
  import page_bus_pkg::*;
#(
  parameter int HI_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic            is_data,
  input  logic [1:0]      mode,
  input  logic [HI_W-1:0] hi_in,
  output logic            miss
);

  logic [HI_W-1:0] page_q;
  logic            valid_q;
  logic            force_q;
  logic            same_page;

  assign same_page = (page_q == hi_in);
  assign miss      = miss_rule(valid_q, force_q, is_data, mode, same_page);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q  <= '0;
      valid_q <= 1'b0;
      force_q <= 1'b0;
    end else if (take) begin
      if (miss) begin
        page_q  <= hi_in;
        valid_q <= 1'b1;
      end
      if (!is_data)            force_q <= 1'b0;
      else if (mode == PG_ONE) force_q <= 1'b1;
    end
  end

  a_r1_invalid_page_misses: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !valid_q) |-> miss);

  a_r5_four_cycle_data_hits: assert property (@(posedge clk) disable iff (!rst_n)
    (take && valid_q && is_data && mode[1]) |-> !miss);

  a_r3_one_cycle_data_arms_force: assert property (@(posedge clk) disable iff (!rst_n)
    (take && is_data && mode == PG_ONE) |=> force_q);

  a_r4_miss_stores_page: assert property (@(posedge clk) disable iff (!rst_n)
    (take && miss) |=> (valid_q && page_q == $past(hi_in)));

endmodule

// File: rtl/xfer_timer.sv
module xfer_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;

  assign last = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (run && !last)   cnt_q <= cnt_q - 1'b1;
  end

  a_r7_load_takes_value: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));

  a_r7_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !last && !load) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/port_steer.sv
module port_steer #(
  parameter int DW = 8
) (
  input  logic          layout,
  input  logic          addr_phase,
  input  logic          data_phase,
  input  logic          is_write,
  input  logic [DW-1:0] hi_byte,
  input  logic [DW-1:0] lo_byte,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] p0_in,
  input  logic [DW-1:0] p2_in,
  output logic [DW-1:0] p0_out,
  output logic          p0_oe,
  output logic [DW-1:0] p2_out,
  output logic          p2_oe,
  output logic [DW-1:0] rdata
);

  always_comb begin
    p0_out = '0;
    p0_oe  = 1'b0;
    p2_out = '0;
    p2_oe  = 1'b0;
    if (addr_phase) begin
      p2_out = hi_byte;
      p2_oe  = 1'b1;
      if (layout) begin
        p0_out = lo_byte;
        p0_oe  = 1'b1;
      end
    end else if (data_phase) begin
      if (!layout) begin
        p2_out = lo_byte;
        p2_oe  = 1'b1;
        if (is_write) begin
          p0_out = wdata;
          p0_oe  = 1'b1;
        end
      end else begin
        p0_out = lo_byte;
        p0_oe  = 1'b1;
        if (is_write) begin
          p2_out = wdata;
          p2_oe  = 1'b1;
        end
      end
    end
  end

  assign rdata = layout ? p2_in : p0_in;

endmodule

// File: rtl/page_bus_seq.sv
module page_bus_seq
  import page_bus_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int STRETCH_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [1:0]           req_kind,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  input  logic [1:0]           page_mode,
  input  logic                 bus_layout,
  input  logic [STRETCH_W-1:0] stretch,
  output logic                 rsp_ready,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic                 ale,
  output logic                 psen,
  output logic                 rd_strobe,
  output logic                 wr_strobe,
  output logic [DATA_W-1:0]    p0_out,
  output logic                 p0_oe,
  input  logic [DATA_W-1:0]    p0_in,
  output logic [DATA_W-1:0]    p2_out,
  output logic                 p2_oe,
  input  logic [DATA_W-1:0]    p2_in
);

  localparam int HI_W    = ADDR_W - DATA_W;
  localparam int MAX_LEN = 4 + 4 * ((1 << STRETCH_W) - 1);
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  bus_state_t          state_q;
  logic [1:0]          kind_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   wdata_q;
  logic                layout_q;

  // Named internal events.
  logic                in_miss;
  logic                in_xfer;
  logic                xfer_last;
  logic                accept;
  logic                page_miss;
  logic                req_is_data;
  logic                q_is_data;
  logic                q_is_write;
  logic [CNT_W-1:0]    len_m1;
  logic [DATA_W-1:0]   steer_rdata;

  assign in_miss     = (state_q == BUS_MISS);
  assign in_xfer     = (state_q == BUS_XFER);
  assign req_is_data = (req_kind != KIND_CODE);
  assign q_is_data   = (kind_q != KIND_CODE);
  assign q_is_write  = (kind_q == KIND_WRITE);
  assign accept      = req_valid && ((state_q == BUS_IDLE) || (in_xfer && xfer_last));
  assign len_m1      = CNT_W'(strobe_clocks(req_is_data, page_mode, int'(stretch)) - 1);

  page_tracker #(.HI_W(HI_W)) u_tracker (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (accept),
    .is_data (req_is_data),
    .mode    (page_mode),
    .hi_in   (req_addr[ADDR_W-1 -: HI_W]),
    .miss    (page_miss)
  );

  xfer_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (len_m1),
    .run      (in_xfer),
    .last     (xfer_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= BUS_IDLE;
      kind_q   <= KIND_CODE;
      addr_q   <= '0;
      wdata_q  <= '0;
      layout_q <= 1'b0;
    end else if (accept) begin
      state_q  <= page_miss ? BUS_MISS : BUS_XFER;
      kind_q   <= req_kind;
      addr_q   <= req_addr;
      wdata_q  <= req_wdata;
      layout_q <= bus_layout;
    end else begin
      case (state_q)
        BUS_MISS: state_q <= BUS_XFER;
        BUS_XFER: if (xfer_last) state_q <= BUS_IDLE;
        default:  state_q <= BUS_IDLE;
      endcase
    end
  end

  port_steer #(.DW(DATA_W)) u_steer (
    .layout     (layout_q),
    .addr_phase (in_miss),
    .data_phase (in_xfer),
    .is_write   (q_is_write),
    .hi_byte    (DATA_W'(addr_q[ADDR_W-1 -: HI_W])),
    .lo_byte    (addr_q[DATA_W-1:0]),
    .wdata      (wdata_q),
    .p0_in      (p0_in),
    .p2_in      (p2_in),
    .p0_out     (p0_out),
    .p0_oe      (p0_oe),
    .p2_out     (p2_out),
    .p2_oe      (p2_oe),
    .rdata      (steer_rdata)
  );

  assign ale       = in_miss;
  assign psen      = in_xfer && !q_is_data;
  assign rd_strobe = in_xfer && q_is_data && !q_is_write;
  assign wr_strobe = in_xfer && q_is_write;
  assign rsp_ready = in_xfer && xfer_last;
  assign rsp_rdata = (rsp_ready && !q_is_write) ? steer_rdata : '0;

  a_r2_ale_single_clock: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  a_r2_ale_then_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> (psen || rd_strobe || wr_strobe));

  a_r6_one_strobe_at_most: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({psen, rd_strobe, wr_strobe, ale}));

  a_r10_ready_inside_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> (psen || rd_strobe || wr_strobe));

  a_r6_hit_fetch_keeps_psen: assert property (@(posedge clk) disable iff (!rst_n)
    (psen && accept && !page_miss && req_kind == KIND_CODE) |=> psen);

  a_r11_busy_holds_request: assert property (@(posedge clk) disable iff (!rst_n)
    (in_xfer && !xfer_last) |=> $stable(addr_q));

endmodule

// File: tb/test_page_bus_seq.sv
module test_page_bus_seq;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0]  kind;
    logic [15:0] addr;
    logic [7:0]  wd;
    logic [1:0]  mode;
    logic        lay;
    logic [2:0]  st;
    logic [7:0]  rdv;
    logic        miss;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    '{2'd0, 16'h1234, 8'h00, 2'b01, 1'b0, 3'd0, 8'hA5, 1'b1},
    '{2'd0, 16'h1280, 8'h00, 2'b01, 1'b0, 3'd0, 8'h5A, 1'b0},
    '{2'd0, 16'h1300, 8'h00, 2'b01, 1'b0, 3'd0, 8'h11, 1'b1},
    '{2'd1, 16'h1344, 8'h00, 2'b01, 1'b0, 3'd0, 8'h3C, 1'b0},
    '{2'd2, 16'h2010, 8'h77, 2'b01, 1'b0, 3'd1, 8'h00, 1'b1},
    '{2'd0, 16'h2000, 8'h00, 2'b10, 1'b1, 3'd0, 8'h81, 1'b0},
    '{2'd1, 16'h5566, 8'h00, 2'b10, 1'b1, 3'd0, 8'h99, 1'b0},
    '{2'd0, 16'h2002, 8'h00, 2'b10, 1'b1, 3'd0, 8'h6E, 1'b0},
    '{2'd2, 16'h2000, 8'hC3, 2'b00, 1'b0, 3'd0, 8'h00, 1'b1},
    '{2'd0, 16'h2004, 8'h00, 2'b00, 1'b0, 3'd0, 8'h27, 1'b1},
    '{2'd0, 16'h2006, 8'h00, 2'b00, 1'b0, 3'd0, 8'hD4, 1'b0},
    '{2'd1, 16'h7F01, 8'h00, 2'b10, 1'b0, 3'd2, 8'h42, 1'b0},
    '{2'd0, 16'h2100, 8'h00, 2'b10, 1'b1, 3'd0, 8'hB7, 1'b1},
    '{2'd2, 16'h21FF, 8'h18, 2'b01, 1'b1, 3'd0, 8'h00, 1'b0},
    '{2'd1, 16'h3300, 8'h00, 2'b11, 1'b0, 3'd0, 8'h6B, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [1:0] req_kind = '0;
  logic [15:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic [1:0] page_mode = '0;
  logic       bus_layout = 1'b0;
  logic [2:0] stretch = '0;
  logic [7:0] p0_in = '0;
  logic [7:0] p2_in = '0;
  logic       rsp_ready, ale, psen, rd_strobe, wr_strobe, p0_oe, p2_oe;
  logic [7:0] rsp_rdata, p0_out, p2_out;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_bus_seq i_page_bus_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .page_mode(page_mode),
    .bus_layout(bus_layout), .stretch(stretch), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .ale(ale), .psen(psen), .rd_strobe(rd_strobe),
    .wr_strobe(wr_strobe), .p0_out(p0_out), .p0_oe(p0_oe), .p0_in(p0_in),
    .p2_out(p2_out), .p2_oe(p2_oe), .p2_in(p2_in)
  );

  function automatic int want_width(input logic [1:0] kind, input logic [1:0] mode,
                                    input logic [2:0] st);
    int base;
    if (kind == 2'd0) return 1;
    base = (mode == 2'b00) ? 1 : ((mode == 2'b01) ? 2 : 4);
    return base + (int'(st) << 2);
  endfunction

  function automatic string miss_req(input int idx, input vec_t v);
    if (idx == 0) return "R1";
    if (v.kind == 2'd0) return (v.mode == 2'b00) ? "R3" : "R2";
    if (v.mode == 2'b00) return "R3";
    if (v.mode == 2'b01) return "R4";
    return "R5";
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive_req(input vec_t v);
    req_kind   = v.kind;
    req_addr   = v.addr;
    req_wdata  = v.wd;
    page_mode  = v.mode;
    bus_layout = v.lay;
    stretch    = v.st;
    p0_in      = v.lay ? ~v.rdv : v.rdv;
    p2_in      = v.lay ? v.rdv : ~v.rdv;
    req_valid  = 1'b1;
  endtask

  task automatic do_access(input vec_t v, output int ale_cnt, output int width,
                           output logic [7:0] rdata, output bit port_ok);
    bit done;
    @(negedge clk);
    drive_req(v);
    @(posedge clk);
    #1 req_valid = 1'b0;
    ale_cnt = 0; width = 0; port_ok = 1'b1; done = 1'b0; rdata = '0;
    for (int i = 0; i < 100 && !done; i++) begin
      @(negedge clk);
      if (ale) begin
        ale_cnt++;
        if (width != 0 || p2_out !== v.addr[15:8] || !p2_oe) port_ok = 1'b0;
        if (v.lay && (p0_out !== v.addr[7:0] || !p0_oe)) port_ok = 1'b0;
      end
      if (psen || rd_strobe || wr_strobe) begin
        width++;
        if (!v.lay) begin
          if (p2_out !== v.addr[7:0] || !p2_oe) port_ok = 1'b0;
          if (v.kind == 2'd2) begin
            if (p0_out !== v.wd || !p0_oe) port_ok = 1'b0;
          end else if (p0_oe) port_ok = 1'b0;
        end else begin
          if (p0_out !== v.addr[7:0] || !p0_oe) port_ok = 1'b0;
          if (v.kind == 2'd2) begin
            if (p2_out !== v.wd || !p2_oe) port_ok = 1'b0;
          end else if (p2_oe) port_ok = 1'b0;
        end
      end
      if (rsp_ready) begin
        done = 1'b1;
        rdata = rsp_rdata;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      failures++;
      $display("FAIL R11 watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int ac, w;
    logic [7:0] rd;
    bit pok;
    vec_t v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(!ale && !psen && !rd_strobe && !wr_strobe, "R1", "strobes after reset",
          {ale, psen, rd_strobe, wr_strobe}, 0);
    check(!rsp_ready && !p0_oe && !p2_oe, "R1", "ready/oe after reset",
          {rsp_ready, p0_oe, p2_oe}, 0);

    for (int k = 0; k < NV; k++) begin
      v = TBL[k];
      do_access(v, ac, w, rd, pok);
      check(ac == (v.miss ? 1 : 0), miss_req(k, v), $sformatf("ale count vec %0d", k),
            ac, v.miss ? 1 : 0);
      check(w == want_width(v.kind, v.mode, v.st), (v.kind == 2'd0) ? "R6" : "R7",
            $sformatf("strobe width vec %0d", k), w, want_width(v.kind, v.mode, v.st));
      check(pok, v.lay ? "R9" : "R8", $sformatf("port contents vec %0d", k), pok, 1);
      if (v.kind != 2'd2)
        check(rd == v.rdv, "R10", $sformatf("read byte vec %0d", k), rd, v.rdv);
      @(negedge clk);
      check(!rsp_ready, "R10", $sformatf("ready single pulse vec %0d", k), rsp_ready, 0);
    end

    // R6: back-to-back same-page fetches keep psen high
    v = '{2'd0, 16'h2110, 8'h00, 2'b01, 1'b0, 3'd0, 8'h12, 1'b0};
    @(negedge clk);
    drive_req(v);
    @(posedge clk);
    #1 req_valid = 1'b0;
    @(negedge clk);
    check(psen && rsp_ready && !ale, "R6", "first hit fetch", {psen, rsp_ready, ale}, 3'b110);
    v.addr = 16'h2112;
    drive_req(v);
    @(posedge clk);
    #1 req_valid = 1'b0;
    @(negedge clk);
    check(psen && !ale && rsp_ready, "R6", "psen continuous on second hit",
          {psen, ale, rsp_ready}, 3'b101);
    @(negedge clk);
    check(!psen && !rsp_ready, "R10", "bus idle after chain", {psen, rsp_ready}, 0);

    // R11: request pulse during a busy strobe is ignored
    v = '{2'd1, 16'h2100, 8'h00, 2'b01, 1'b0, 3'd2, 8'h64, 1'b0};
    @(negedge clk);
    drive_req(v);
    @(posedge clk);
    #1 req_valid = 1'b0;
    w = 0; ac = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (ale) ac++;
      if (rd_strobe) w++;
      if (i == 2) begin
        req_kind = 2'd0; req_addr = 16'h4400; req_valid = 1'b1;
        @(posedge clk);
        #1 req_valid = 1'b0;
      end else if (rsp_ready) break;
    end
    check(w == 10 && ac == 0, "R11", "busy read width unchanged", w, 10);
    ac = 0; w = 0;
    repeat (3) begin
      @(negedge clk);
      if (ale) ac++;
      if (psen) w++;
    end
    check(ac == 0 && w == 0, "R11", "no activity from ignored pulse", ac + w, 0);
    v = '{2'd0, 16'h2120, 8'h00, 2'b01, 1'b0, 3'd0, 8'h0F, 1'b0};
    do_access(v, ac, w, rd, pok);
    check(ac == 0, "R11", "page unchanged by ignored pulse", ac, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule